// File: doc/BRIEF.md
# Shared-Function Pin Controller with Edge Interrupts

This block manages five multiplexed I/O pins from five byte-wide configuration registers on a simple synchronous register bus. Each register sets the pin's direction, drive type (push-pull or open drain), pull-up, input threshold select and interrupt options. The first three pins can also serve as dedicated edge-triggered interrupt inputs, each with its own request line. The last two pins can also feed capture-timer inputs or carry single-cycle timer pulses out to the pad.

The interrupt edge detector looks at the effective pin value. For an input this is the synchronized pad. For an output it is the data bit, so software can raise a request by writing the data bit. A pending flag per interrupt pin is sticky. It is cleared by a write-one-to-clear strobe, and it reaches the request output only while that pin's interrupt enable is set. The timer pulses come in from outside and leave through the pad drivers whatever the interrupt enable holds.

Top module: `shared_pin_ctrl`

## Requirements
- R1: After synchronous reset, every configuration register reads 0 and pad_oe, pad_out, pad_pu, pad_ttl and irq_req are all 0.
- R2: Pins 0..4 own the registers at bus addresses 0x07..0x0B in that order. A write takes effect at the clock edge where bus_we is high. bus_rdata shows the register selected by bus_addr one cycle later. Any other address reads as 0.
- R3: Register bit 3 always reads 0, and bit 7 reads 0 on pins 0..2. Writes to these bits are dropped.
- R4: The bit fields are: bit 0 output enable, bit 1 pull-up, bit 2 open drain, bit 4 threshold select, bit 5 active-low, bit 6 interrupt enable, bit 7 timer-output select (pins 3..4 only). With open drain clear, pad_oe equals bit 0 and pad_out equals bit 0 AND the pin value, one cycle after the inputs. pad_pu and pad_ttl follow bits 1 and 4.
- R5: With open drain set, pad_out is 0 and pad_oe is high only when bit 0 is set and the pin value is 0.
- R6: On pins 0..2, a rising edge of the effective value sets that pin's pending flag when active-low is 0, and a falling edge sets it when active-low is 1. The flag shows on irq_req within four cycles of the pad change.
- R7: irq_req[i] is pending AND interrupt enable, and a pending flag stays set until irq_clr[i]. If an edge and irq_clr land in the same cycle, the flag stays set.
- R8: With output enable set on pins 0..2, the effective value is the data bit, so a data-bit edge raises the request.
- R9: The detector compares the polarity-adjusted value, so flipping active-low while the pin is at its inactive level sets pending. irq_clr then removes it.
- R10: On pins 3..4, pad_out carries tmr_pulse one cycle later when bit 7 and bit 0 are set, whatever the interrupt enable holds. With bit 7 clear, the data bit drives the pad.
- R11: cap_in[j] is the registered effective value of pin 3+j: the pad when bit 0 is clear, otherwise the data bit (bit 7 clear) or the pulse (bit 7 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pdata | input | 5 | Port data-register bits, one per pin |
| pad_in | input | 5 | Pad input levels |
| pad_oe | output | 5 | Pad driver enable |
| pad_out | output | 5 | Pad driven level |
| pad_pu | output | 5 | Pull-up enable to pad |
| pad_ttl | output | 5 | Input threshold select to pad |
| irq_clr | input | 3 | Write-one-to-clear strobes for pending flags |
| irq_req | output | 3 | Interrupt requests for pins 0..2 |
| tmr_pulse | input | 2 | Single-cycle timer pulses for pins 3..4 |
| cap_in | output | 2 | Capture-timer input values for pins 3..4 |

## Verification
Two functions can meet in one cycle: a newly detected edge setting a pending flag, and the irq_clr strobe clearing it. The bench raises the pad, waits the two synchronizer stages, and then asserts irq_clr in exactly the cycle the edge is registered. It judges the result by requiring irq_req to stay high afterwards, since a set must not be lost to a simultaneous clear.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] WMASK_IRQ = 8'h77;
  localparam logic [CFG_W-1:0] WMASK_TMR = 8'hF7;

  typedef struct packed {
    logic tsel;   // bit 7: timer pulse select
    logic ie;     // bit 6: interrupt enable
    logic alow;   // bit 5: active-low edge
    logic ttl;    // bit 4: threshold select
    logic rsv;    // bit 3: reserved
    logic od;     // bit 2: open drain
    logic pu;     // bit 1: pull-up
    logic oe;     // bit 0: output enable
  } pin_cfg_t;
endpackage

// File: rtl/spc_regs.sv
module spc_regs
  import spc_pkg::*;
#(
  parameter int NUM_PINS  = 5,
  parameter int NUM_IRQ   = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CFG_W-1:0]         wdata,
  output pin_cfg_t [NUM_PINS-1:0]  cfg,
  output logic [CFG_W-1:0]         rdata
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
    localparam logic [CFG_W-1:0]  MASK  = (p < NUM_IRQ) ? WMASK_IRQ : WMASK_TMR;
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(BASE_ADDR + p);
    always_ff @(posedge clk) begin
      if (rst)
        cfg[p] <= '0;
      else if (we && addr == PADDR)
        cfg[p] <= pin_cfg_t'(wdata & MASK);
    end
  end

  logic [CFG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (addr == ADDR_W'(BASE_ADDR + p)) rd_mux = cfg[p];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/spc_pad_drive.sv
module spc_pad_drive
  import spc_pkg::*;
#(
  parameter int NUM_IRQ = 3,
  parameter int NUM_TMR = 2,
  localparam int NUM_PINS = NUM_IRQ + NUM_TMR
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pin_cfg_t [NUM_PINS-1:0] cfg,
  input  logic [NUM_PINS-1:0]     pdata,
  input  logic [NUM_PINS-1:0]     pad_in,
  input  logic [NUM_TMR-1:0]      tmr_pulse,
  output logic [NUM_PINS-1:0]     eff,
  output logic [NUM_PINS-1:0]     pad_oe,
  output logic [NUM_PINS-1:0]     pad_out,
  output logic [NUM_PINS-1:0]     pad_pu,
  output logic [NUM_PINS-1:0]     pad_ttl,
  output logic [NUM_TMR-1:0]      cap_in
);
  logic [NUM_PINS-1:0] val;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p >= NUM_IRQ) begin : g_tmr
      assign val[p] = (cfg[p].tsel && cfg[p].oe) ? tmr_pulse[p-NUM_IRQ] : pdata[p];
    end else begin : g_gpio
      assign val[p] = pdata[p];
    end
    assign eff[p] = cfg[p].oe ? val[p] : pad_in[p];

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[p]  <= 1'b0;
        pad_out[p] <= 1'b0;
        pad_pu[p]  <= 1'b0;
        pad_ttl[p] <= 1'b0;
      end else begin
        pad_oe[p]  <= cfg[p].oe & (~cfg[p].od | ~val[p]);
        pad_out[p] <= cfg[p].oe & ~cfg[p].od & val[p];
        pad_pu[p]  <= cfg[p].pu;
        pad_ttl[p] <= cfg[p].ttl;
      end
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) cap_in[t] <= 1'b0;
      else     cap_in[t] <= eff[NUM_IRQ+t];
    end
  end
endmodule

// File: rtl/spc_edge_irq.sv
module spc_edge_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic alow,
  input  logic ie,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic lvl, lvl_q, pend_q, edge_hit;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  // polarity-adjusted level: flipping alow can itself look like an edge
  assign lvl      = sync_q[SYNC_STAGES-1] ^ alow;
  assign edge_hit = lvl & ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl;
      pend_q <= edge_hit | (pend_q & ~clr);
    end
  end

  assign req = pend_q & ie;
endmodule

// File: rtl/shared_pin_ctrl.sv
module shared_pin_ctrl
  import spc_pkg::*;
#(
  parameter int NUM_IRQ     = 3,
  parameter int NUM_TMR     = 2,
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 7,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS   = NUM_IRQ + NUM_TMR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CFG_W-1:0]    bus_wdata,
  output logic [CFG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_ttl,
  input  logic [NUM_IRQ-1:0]  irq_clr,
  output logic [NUM_IRQ-1:0]  irq_req,
  input  logic [NUM_TMR-1:0]  tmr_pulse,
  output logic [NUM_TMR-1:0]  cap_in
);
  pin_cfg_t [NUM_PINS-1:0] cfg;
  logic [NUM_PINS-1:0]     eff;

  spc_regs #(
    .NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cfg(cfg), .rdata(bus_rdata)
  );

  spc_pad_drive #(.NUM_IRQ(NUM_IRQ), .NUM_TMR(NUM_TMR)) u_drive (
    .clk(clk), .rst(rst), .cfg(cfg), .pdata(pdata), .pad_in(pad_in),
    .tmr_pulse(tmr_pulse), .eff(eff), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_ttl(pad_ttl), .cap_in(cap_in)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    spc_edge_irq #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .din(eff[i]), .alow(cfg[i].alow),
      .ie(cfg[i].ie), .clr(irq_clr[i]), .req(irq_req[i])
    );
  end
endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
#(
  parameter int NUM_IRQ = 3,
  parameter int NUM_TMR = 2,
  localparam int NUM_PINS = NUM_IRQ + NUM_TMR
) (
  input logic                    clk,
  input logic                    rst,
  input pin_cfg_t [NUM_PINS-1:0] cfg,
  input logic [NUM_PINS-1:0]     pad_oe,
  input logic [NUM_PINS-1:0]     pad_out,
  input logic [NUM_IRQ-1:0]      irq_clr,
  input logic [NUM_IRQ-1:0]      irq_req,
  input logic [NUM_TMR-1:0]      tmr_pulse
);
  // R1: one cycle after reset the pad drivers are idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && irq_req == '0));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_od
    // R5: an open-drain pin never drives high
    p_od_no_high_r5: assert property (@(posedge clk) disable iff (rst)
      cfg[p].od |=> !pad_out[p]);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    // R7: a request holds until cleared or disabled
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (irq_req[i] && !irq_clr[i]) |=> (irq_req[i] || !cfg[i].ie));
    // R7: a request only rises with its enable set
    p_req_en_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_req[i]) |-> cfg[i].ie);
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    // R10: the timer pulse reaches the pad one cycle later, interrupt enable ignored
    p_tmr_pass_r10: assert property (@(posedge clk) disable iff (rst)
      (cfg[NUM_IRQ+t].tsel && cfg[NUM_IRQ+t].oe && !cfg[NUM_IRQ+t].od && tmr_pulse[t])
        |=> pad_out[NUM_IRQ+t]);
  end
endmodule

bind shared_pin_ctrl spc_checker #(.NUM_IRQ(NUM_IRQ), .NUM_TMR(NUM_TMR)) u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .pad_oe(pad_oe), .pad_out(pad_out),
  .irq_clr(irq_clr), .irq_req(irq_req), .tmr_pulse(tmr_pulse)
);

// File: tb/tb_shared_pin_ctrl.sv
module tb_shared_pin_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [4:0] pdata = '0, pad_in = '0, pad_oe, pad_out, pad_pu, pad_ttl;
  logic [2:0] irq_clr = '0, irq_req;
  logic [1:0] tmr_pulse = '0, cap_in;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_pin_ctrl dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pdata(pdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .pad_ttl(pad_ttl), .irq_clr(irq_clr),
    .irq_req(irq_req), .tmr_pulse(tmr_pulse), .cap_in(cap_in)
  );

  // {address, write data, expected readback}
  localparam logic [23:0] VEC [10] = '{
    24'h07_FF_77,  // R3: bit7 and bit3 dropped on pin 0
    24'h08_5A_52,  // R3
    24'h09_08_00,  // R3: only bit3
    24'h0A_FF_F7,  // R3: bit7 kept on timer pin
    24'h0B_81_81,  // R2
    24'h06_FF_00,  // R2: unmapped below
    24'h0C_FF_00,  // R2: unmapped above
    24'h00_FF_00,  // R2
    24'h07_00_00,  // R2
    24'h0A_00_00   // R2
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic clr(int i);
    @(negedge clk);
    irq_clr[i] = 1'b1;
    @(negedge clk);
    irq_clr[i] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq_req", irq_req, 0);
    rd(8'h0B, r);
    chk("R1 cfg", r, 0);

    // R2/R3 vector walk
    for (int k = 0; k < 10; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], r);
      chk("R2/R3 readback", r, VEC[k][7:0]);
    end
    for (int a = 7; a < 12; a++) wr(8'(a), 8'h00);

    // R6 rising edge on pin 0
    wr(8'h07, 8'h40);
    tick(5); clr(0);
    chk("R7 cleared", irq_req[0], 0);
    @(negedge clk) pad_in[0] = 1'b1;
    tick(4);
    chk("R6 rising", irq_req[0], 1);
    tick(5);
    chk("R7 sticky", irq_req[0], 1);
    clr(0);
    chk("R7 clear", irq_req[0], 0);

    // R6 falling edge
    wr(8'h07, 8'h60);
    tick(4);
    chk("R6 no edge on high", irq_req[0], 0);
    @(negedge clk) pad_in[0] = 1'b0;
    tick(4);
    chk("R6 falling", irq_req[0], 1);
    clr(0);

    // R7 enable gating
    wr(8'h07, 8'h20);
    @(negedge clk) pad_in[0] = 1'b1;
    tick(4);
    @(negedge clk) pad_in[0] = 1'b0;
    tick(4);
    chk("R7 gated off", irq_req[0], 0);
    wr(8'h07, 8'h60);
    chk("R7 enable reveals pending", irq_req[0], 1);
    clr(0);

    // R7 edge and clear in the same cycle
    wr(8'h07, 8'h40);
    tick(4); clr(0);
    @(negedge clk) pad_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk) irq_clr[0] = 1'b1;
    @(negedge clk) irq_clr[0] = 1'b0;
    chk("R7 set wins over clear", irq_req[0], 1);
    clr(0);
    chk("R7 clear after collision", irq_req[0], 0);

    // R9 spurious edge from polarity flip
    wr(8'h08, 8'h40);
    tick(4); clr(1);
    chk("R9 idle", irq_req[1], 0);
    wr(8'h08, 8'h60);
    tick(4);
    chk("R9 spurious edge", irq_req[1], 1);
    clr(1); tick(4);
    chk("R9 cleared", irq_req[1], 0);

    // R8 output write raises request
    wr(8'h09, 8'h41);
    tick(4); clr(2);
    chk("R8 idle", irq_req[2], 0);
    @(negedge clk) pdata[2] = 1'b1;
    tick(4);
    chk("R8 output write irq", irq_req[2], 1);
    chk("R4 push-pull oe", pad_oe[2], 1);
    chk("R4 push-pull out", pad_out[2], 1);

    // R10 timer pulse passthrough, interrupt disabled
    wr(8'h0A, 8'h81);
    tick(1);
    chk("R10 oe", pad_oe[3], 1);
    chk("R10 idle", pad_out[3], 0);
    @(negedge clk) tmr_pulse[0] = 1'b1;
    @(negedge clk);
    chk("R10 pulse out", pad_out[3], 1);
    tmr_pulse[0] = 1'b0;
    @(negedge clk);
    chk("R10 pulse ends", pad_out[3], 0);
    wr(8'h0A, 8'h01);
    @(negedge clk) tmr_pulse[0] = 1'b1;
    @(negedge clk);
    chk("R10 select clear ignores pulse", pad_out[3], 0);
    tmr_pulse[0] = 1'b0;

    // R11 capture input
    @(negedge clk) pad_in[4] = 1'b1;
    @(negedge clk);
    chk("R11 cap from pad", cap_in[1], 1);
    pdata[4] = 1'b0;
    wr(8'h0B, 8'h01);
    tick(1);
    chk("R11 cap from data 0", cap_in[1], 0);
    @(negedge clk) pdata[4] = 1'b1;
    @(negedge clk);
    chk("R11 cap from data 1", cap_in[1], 1);

    // R5 open drain
    wr(8'h0B, 8'h05);
    tick(1);
    chk("R5 od high releases", pad_oe[4], 0);
    chk("R5 od out", pad_out[4], 0);
    @(negedge clk) pdata[4] = 1'b0;
    @(negedge clk);
    chk("R5 od low drives", pad_oe[4], 1);
    chk("R5 od out low", pad_out[4], 0);

    // R4 pull-up and threshold
    wr(8'h0B, 8'h12);
    tick(1);
    chk("R4 pull-up", pad_pu[4], 1);
    chk("R4 threshold", pad_ttl[4], 1);
    chk("R4 oe off", pad_oe[4], 0);

    finish_run();
  end
endmodule